// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller

This block gathers 96 level-sensitive interrupt sources, arranged as three banks of 32, and presents two requests to a processor: a normal request (IRQ) and a fast request (FIQ). Each source carries a 6-bit priority and a one-bit route that sends it to IRQ or to FIQ. Two arbiters of the same design, one per output, pick the pending, unmasked source with the best priority. When an output is armed, the global gate is open and a candidate exists, the output asserts and latches the winning line number. It stays asserted until software re-arms it through the control register.

Software reaches the block through a 4 KB window of 32-bit registers. The window holds global registers, a per-bank group at 0x80 + 0x20 × bank, and per-line configuration words at 0x100 + 0x80 × bank + 4 × line. Each bank's mask has set and clear aliases, and each bank has software-interrupt set and clear registers, so a single access can change one bit without a read-modify-write. Hardware inputs are sampled on the clock. A write updates state at the clock edge that accepts it. A read returns the state held before that edge, and the data appears on `rdata_o` with `rvalid_o` one cycle later. An output asserts on the clock edge that follows the state change which made a candidate available.

Top module: `banked_intc`

## Requirements
- R1: After reset: every mask bit is 1; pending, raw-input, software, priority and route state are 0; both outputs are low and both are armed; the control register reads 0; the source registers read 0. Offset 0x00 returns the REVISION parameter (default 0x21) and offset 0x14 returns 1.
- R2: Sysconfig (0x10) keeps bit 0, idle (0x50) keeps bits [1:0], and protection (0x4C) always reads 0. A line word keeps priority in bits [7:2] and the route in bit 0, and reads 0 in bit 1. Writes to read-only offsets have no effect, and undefined offsets read 0.
- R3: Within a bank group, +0x04 replaces the mask, +0x08 clears the mask bits written as 1, and +0x0C sets the mask bits written as 1. +0x08 and +0x0C read 0.
- R4: A rising input sets its raw bit (bank +0x00) and its pending bit. A falling input in a bank sets that bank's pending to raw inputs OR software bits.
- R5: Bank +0x10 ORs the written value into the software bits and into pending, and reads back the software bits. Bank +0x14 clears the written software bits and then sets pending to software bits AND raw inputs.
- R6: Bank +0x18 reads pending AND NOT mask AND NOT route. Bank +0x1C reads pending AND NOT mask AND route.
- R7: The arbiter selects the lowest priority value. A tie goes to the highest line number. The line number is 32 × bank + line.
- R8: An armed output with a candidate and an open global gate asserts, stores the winner in its source register (0x40 for IRQ, 0x44 for FIQ) and becomes disarmed. It then stays asserted even after the source goes away.
- R9: A control (0x48) write with bit 0 set drops IRQ and re-arms it, and bit 1 does the same for FIQ. A re-armed output can assert again on the next cycle.
- R10: Control bit 2 set closes the global gate, which prevents any new assertion, and bit 2 clear reopens it. A read of 0x48 returns the gate state in bit 2.
- R11: A sysconfig write with bit 1 set returns the whole controller to its R1 state.
- R12: A bank group access with bank index 3 or more reads 0 and changes no state.
- R13: A source routed to FIQ drives fiq_o and 0x44, and leaves IRQ unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 96 | Level interrupt sources, synchronous to clk_i |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is a tied priority across banks together with a source register that must not move while its output is disarmed. To set it up, the stimulus closes the global gate, builds pending state in three banks with software-set bits, and gives two lines in different banks equal priority. It then opens the gate, so the tie resolves in one arbitration. It then changes one priority and re-arms, which shows the source register following the new winner only after the re-arm. The stimulus also sets a software bit on a line whose input is high and clears a different software bit. The resulting pending value can only come from the AND rule.

// File: rtl/banked_intc_pkg.sv
package banked_intc_pkg;
  localparam logic [11:0] OFS_REV    = 12'h000;
  localparam logic [11:0] OFS_SYSC   = 12'h010;
  localparam logic [11:0] OFS_STAT   = 12'h014;
  localparam logic [11:0] OFS_SRC_I  = 12'h040;
  localparam logic [11:0] OFS_SRC_F  = 12'h044;
  localparam logic [11:0] OFS_CTRL   = 12'h048;
  localparam logic [11:0] OFS_PROT   = 12'h04C;
  localparam logic [11:0] OFS_IDLE   = 12'h050;

  // word index inside a bank group; decoded by the bank
  typedef enum logic [2:0] {
    BR_RAW  = 3'd0,
    BR_MASK = 3'd1,
    BR_MCLR = 3'd2,
    BR_MSET = 3'd3,
    BR_SSET = 3'd4,
    BR_SCLR = 3'd5,
    BR_PIRQ = 3'd6,
    BR_PFIQ = 3'd7
  } bank_reg_e;

  localparam int LINES_PER_BANK = 32;
endpackage

// File: rtl/banked_intc_bank.sv
module banked_intc_bank
  import banked_intc_pkg::*;
#(
  parameter int PRIO_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic [31:0]               src_i,
  input  logic                      wr_i,
  input  bank_reg_e                 sel_i,
  input  logic [31:0]               wdata_i,
  input  logic                      ilr_we_i,
  input  logic [4:0]                ilr_line_i,
  output logic [31:0]               raw_o,
  output logic [31:0]               mask_o,
  output logic [31:0]               swi_o,
  output logic [31:0]               pend_o,
  output logic [31:0]               route_o,
  output logic [31:0][PRIO_W-1:0]   prio_o
);
  logic [31:0] raw_q, mask_q, swi_q, pend_q, route_q;
  logic [31:0] mask_n, swi_n, pend_n;
  logic [31:0][PRIO_W-1:0] prio_q;
  logic [31:0] rise, fall;

  assign rise = src_i & ~raw_q;
  assign fall = ~src_i & raw_q;

  always_comb begin
    mask_n = mask_q;
    swi_n  = swi_q;
    pend_n = pend_q;
    if (wr_i) begin
      unique case (sel_i)
        BR_MASK: mask_n = wdata_i;
        BR_MCLR: mask_n = mask_q & ~wdata_i;
        BR_MSET: mask_n = mask_q | wdata_i;
        BR_SSET: begin
          swi_n  = swi_q | wdata_i;
          pend_n = pend_q | wdata_i;
        end
        BR_SCLR: begin
          swi_n  = swi_q & ~wdata_i;
          pend_n = swi_n & raw_q;
        end
        default: ;
      endcase
    end
    // input events apply after the register write of the same cycle
    if (|fall) pend_n = src_i | swi_n;
    else       pend_n = pend_n | rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q   <= '0;
      mask_q  <= '1;
      swi_q   <= '0;
      pend_q  <= '0;
      route_q <= '0;
      prio_q  <= '0;
    end else if (clr_i) begin
      raw_q   <= '0;
      mask_q  <= '1;
      swi_q   <= '0;
      pend_q  <= '0;
      route_q <= '0;
      prio_q  <= '0;
    end else begin
      raw_q  <= src_i;
      mask_q <= mask_n;
      swi_q  <= swi_n;
      pend_q <= pend_n;
      if (ilr_we_i) begin
        prio_q[ilr_line_i]  <= wdata_i[2 +: PRIO_W];
        route_q[ilr_line_i] <= wdata_i[0];
      end
    end
  end

  assign raw_o   = raw_q;
  assign mask_o  = mask_q;
  assign swi_o   = swi_q;
  assign pend_o  = pend_q;
  assign route_o = route_q;
  assign prio_o  = prio_q;
endmodule

// File: rtl/banked_intc_arbiter.sv
module banked_intc_arbiter #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 valid_o,
  output logic [IW-1:0]        idx_o
);
  logic [PW-1:0] best;

  // ascending scan with <= lets the highest index win ties
  always_comb begin
    valid_o = 1'b0;
    best    = '1;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!valid_o || prio_i[i] <= best)) begin
        valid_o = 1'b1;
        best    = prio_i[i];
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import banked_intc_pkg::*;
#(
  parameter int         NUM_BANKS = 3,
  parameter int         PRIO_W    = 6,
  parameter logic [7:0] REVISION  = 8'h21,
  localparam int        NUM_LINES = NUM_BANKS * LINES_PER_BANK,
  localparam int        BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int        SRC_W     = BANK_W + 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] src_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [11:0]          addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 rvalid_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  // decode
  logic [1:0]        bsel2;
  logic [BANK_W-1:0] bsel;
  logic              is_bank, bank_ok;
  bank_reg_e         breg;
  logic [4:0]        ilr_blk;
  logic              is_ilr;
  logic [SRC_W-1:0]  ilr_gl;

  assign bsel2   = addr_i[6:5];
  assign bsel    = bsel2[BANK_W-1:0];
  assign is_bank = (addr_i[11:7] == 5'd1);
  assign bank_ok = int'(bsel2) < NUM_BANKS;
  assign breg    = bank_reg_e'(addr_i[4:2]);
  assign ilr_blk = addr_i[11:7] - 5'd2;
  assign is_ilr  = (addr_i[11:7] >= 5'd2) && (int'(ilr_blk) < NUM_BANKS);
  assign ilr_gl  = {ilr_blk[BANK_W-1:0], addr_i[6:2]};

  logic soft_rst, ctrl_wr;
  assign soft_rst = wr && (addr_i == OFS_SYSC) && wdata_i[1];
  assign ctrl_wr  = wr && (addr_i == OFS_CTRL);

  // banks
  logic [NUM_LINES-1:0]             raw_all, mask_all, swi_all, pend_all, route_all;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    banked_intc_bank #(.PRIO_W(PRIO_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (soft_rst),
      .src_i      (src_i[b*32 +: 32]),
      .wr_i       (wr && is_bank && bank_ok && (bsel == BANK_W'(b))),
      .sel_i      (breg),
      .wdata_i    (wdata_i),
      .ilr_we_i   (wr && is_ilr && (ilr_blk[BANK_W-1:0] == BANK_W'(b))),
      .ilr_line_i (addr_i[6:2]),
      .raw_o      (raw_all[b*32 +: 32]),
      .mask_o     (mask_all[b*32 +: 32]),
      .swi_o      (swi_all[b*32 +: 32]),
      .pend_o     (pend_all[b*32 +: 32]),
      .route_o    (route_all[b*32 +: 32]),
      .prio_o     (prio_all[b*32 +: 32])
    );
  end

  // arbiters: k=0 normal, k=1 fast
  logic [1:0]             arb_valid;
  logic [1:0][SRC_W-1:0]  arb_idx;
  logic [NUM_LINES-1:0]   live;
  assign live = pend_all & ~mask_all;

  for (genvar k = 0; k < 2; k++) begin : g_arb
    banked_intc_arbiter #(.N(NUM_LINES), .PW(PRIO_W), .IW(SRC_W)) u_arb (
      .req_i   (live & ((k == 1) ? route_all : ~route_all)),
      .prio_i  (prio_all),
      .valid_o (arb_valid[k]),
      .idx_o   (arb_idx[k])
    );
  end

  // global state
  logic                  sysc_q, gclosed_q;
  logic [1:0]            idle_q, armed_q, out_q;
  logic [1:0][SRC_W-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sysc_q    <= 1'b0;
      idle_q    <= '0;
      gclosed_q <= 1'b0;
      armed_q   <= '1;
      out_q     <= '0;
      src_q     <= '0;
    end else if (soft_rst) begin
      sysc_q    <= 1'b0;
      idle_q    <= '0;
      gclosed_q <= 1'b0;
      armed_q   <= '1;
      out_q     <= '0;
      src_q     <= '0;
    end else begin
      if (wr && addr_i == OFS_SYSC) sysc_q <= wdata_i[0];
      if (wr && addr_i == OFS_IDLE) idle_q <= wdata_i[1:0];
      if (ctrl_wr) gclosed_q <= wdata_i[2];
      for (int k = 0; k < 2; k++) begin
        if (ctrl_wr && wdata_i[k]) begin
          out_q[k]   <= 1'b0;
          armed_q[k] <= 1'b1;
        end else if (armed_q[k] && arb_valid[k] && !gclosed_q) begin
          out_q[k]   <= 1'b1;
          armed_q[k] <= 1'b0;
          src_q[k]   <= arb_idx[k];
        end
      end
    end
  end

  assign irq_o = out_q[0];
  assign fiq_o = out_q[1];

  // read path
  logic [31:0] rval;
  logic [6:0]  bbase;
  assign bbase = {bsel2, 5'd0};

  always_comb begin
    rval = '0;
    if (is_bank) begin
      if (bank_ok) begin
        unique case (breg)
          BR_RAW:  rval = raw_all[bbase +: 32];
          BR_MASK: rval = mask_all[bbase +: 32];
          BR_SSET: rval = swi_all[bbase +: 32];
          BR_PIRQ: rval = live[bbase +: 32] & ~route_all[bbase +: 32];
          BR_PFIQ: rval = live[bbase +: 32] & route_all[bbase +: 32];
          default: rval = '0;
        endcase
      end
    end else if (is_ilr) begin
      rval[2 +: PRIO_W] = prio_all[ilr_gl];
      rval[0]           = route_all[ilr_gl];
    end else begin
      unique case (addr_i)
        OFS_REV:   rval[7:0]       = REVISION;
        OFS_SYSC:  rval[0]         = sysc_q;
        OFS_STAT:  rval[0]         = 1'b1;
        OFS_SRC_I: rval[SRC_W-1:0] = src_q[0];
        OFS_SRC_F: rval[SRC_W-1:0] = src_q[1];
        OFS_CTRL:  rval[2]         = gclosed_q;
        OFS_IDLE:  rval[1:0]       = idle_q;
        default:   rval = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rval;
    end
  end

  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];
endmodule

// File: rtl/banked_intc_checks.sv
module banked_intc_checks #(
  parameter int NUM_LINES = 96,
  parameter int SRC_W     = 7
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [11:0]           addr_i,
  input logic [31:0]           wdata_i,
  input logic                  rvalid_o,
  input logic                  irq_o,
  input logic                  fiq_o,
  input logic                  soft_rst,
  input logic                  gclosed_q,
  input logic [1:0]            arb_valid,
  input logic [NUM_LINES-1:0]  mask_all,
  input logic [1:0][SRC_W-1:0] src_q
);
  logic ctrl_wr;
  assign ctrl_wr = req_i && we_i && (addr_i == 12'h048) && !soft_rst;

  a_r2_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  a_r8_irq_needs_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(arb_valid[0]));

  a_r13_fiq_needs_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fiq_o) |-> $past(arb_valid[1]));

  a_r10_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) || $rose(fiq_o)) |-> $past(!gclosed_q));

  a_r9_rearm_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[0]) |=> !irq_o);

  a_r9_rearm_fiq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[1]) |=> !fiq_o);

  a_r11_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (&mask_all && !irq_o && !fiq_o));

  a_r7_src_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(src_q[0]) < NUM_LINES) && (int'(src_q[1]) < NUM_LINES));
endmodule

bind banked_intc banked_intc_checks #(.NUM_LINES(NUM_LINES), .SRC_W(SRC_W)) u_checks (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rvalid_o  (rvalid_o),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .soft_rst  (soft_rst),
  .gclosed_q (gclosed_q),
  .arb_valid (arb_valid),
  .mask_all  (mask_all),
  .src_q     (src_q)
);

// File: tb/banked_intc_test.sv
module banked_intc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 96;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic [NL-1:0] src_i = '0;
  logic          req_i = 0, we_i = 0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          rvalid_o, irq_o, fiq_o;

  int n_vec = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  banked_intc uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // monitor: pops expectations as read data returns
  always @(negedge clk_i) begin
    if (rvalid_o) begin
      logic [31:0] e;
      string t;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read data act=%h exp=none", rdata_o);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata_o !== e) begin
          n_bad++;
          $display("FAIL %s act=%h exp=%h", t, rdata_o, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i);
    exp_q.push_back(e); tag_q.push_back(t);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic pin(input logic act, input logic e, input string t);
    n_vec++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1;
    idle(2);
    // R1 reset state
    pin(irq_o, 0, "R1 irq after reset");
    pin(fiq_o, 0, "R1 fiq after reset");
    rd(12'h000, 32'h21, "R1 revision");
    rd(12'h014, 32'h1, "R1 status");
    rd(12'h084, 32'hFFFF_FFFF, "R1 mask bank0");
    rd(12'h0C4, 32'hFFFF_FFFF, "R1 mask bank2");
    rd(12'h048, 32'h0, "R1 control");
    rd(12'h040, 32'h0, "R1 irq source");
    // R2 storage and read-only
    wr(12'h010, 32'h1);  rd(12'h010, 32'h1, "R2 sysconfig bit0");
    wr(12'h050, 32'h7);  rd(12'h050, 32'h3, "R2 idle bits");
    wr(12'h04C, 32'h1);  rd(12'h04C, 32'h0, "R2 protection");
    rd(12'h060, 32'h0, "R2 undefined offset");
    wr(12'h000, 32'h5);  rd(12'h000, 32'h21, "R2 revision read-only");
    wr(12'h194, 32'hFF); rd(12'h194, 32'hFD, "R2 line word bank1 line5");
    wr(12'h194, 32'h0);
    // R3 mask aliases
    wr(12'h084, 32'hFFFF_0000); rd(12'h084, 32'hFFFF_0000, "R3 mask replace");
    wr(12'h088, 32'h000F_0000); rd(12'h084, 32'hFFF0_0000, "R3 mask clear");
    wr(12'h08C, 32'h0000_0001); rd(12'h084, 32'hFFF0_0001, "R3 mask set");
    rd(12'h088, 32'h0, "R3 clear alias reads 0");
    rd(12'h08C, 32'h0, "R3 set alias reads 0");
    wr(12'h084, 32'hFFFF_FFFF);
    // R12 bank index 3
    wr(12'h0E4, 32'h0);  rd(12'h0E4, 32'h0, "R12 bank3 read");
    rd(12'h084, 32'hFFFF_FFFF, "R12 bank0 untouched");
    rd(12'h0C4, 32'hFFFF_FFFF, "R12 bank2 untouched");
    // R4 hardware input, R6 views, R8 fire
    src_i[3] = 1; idle(2);
    rd(12'h080, 32'h8, "R4 raw input");
    rd(12'h098, 32'h0, "R6 masked pending");
    pin(irq_o, 0, "R8 masked stays low");
    wr(12'h088, 32'h8); idle(2);
    pin(irq_o, 1, "R8 irq asserts");
    rd(12'h040, 32'd3, "R8 irq source");
    rd(12'h098, 32'h8, "R6 pending irq view");
    rd(12'h09C, 32'h0, "R6 pending fiq view");
    src_i[3] = 0; idle(2);
    rd(12'h098, 32'h0, "R4 falling clears pending");
    pin(irq_o, 1, "R8 irq sticky");
    wr(12'h048, 32'h1); idle(2);
    pin(irq_o, 0, "R9 irq re-armed low");
    // R5 software set in bank1, line 8 -> 40
    wr(12'h0B0, 32'h100);
    rd(12'h0B0, 32'h100, "R5 software bits");
    rd(12'h0B8, 32'h0, "R6 bank1 masked");
    wr(12'h0A8, 32'h100); idle(2);
    rd(12'h0B8, 32'h100, "R5 software pending");
    pin(irq_o, 1, "R8 software fire");
    rd(12'h040, 32'd40, "R8 bank1 source number");
    wr(12'h0B4, 32'h100);
    rd(12'h0B0, 32'h0, "R5 software cleared");
    rd(12'h0B8, 32'h0, "R5 pending after clear");
    wr(12'h048, 32'h1);
    // R10 gate, R5 AND rule
    wr(12'h048, 32'h4);
    rd(12'h048, 32'h4, "R10 gate readback");
    src_i[4] = 1;
    wr(12'h090, 32'h30);
    wr(12'h088, 32'h30); idle(2);
    rd(12'h098, 32'h30, "R5 set merges");
    pin(irq_o, 0, "R10 closed gate blocks");
    wr(12'h094, 32'h20);
    rd(12'h098, 32'h10, "R5 clear gives swi AND raw");
    rd(12'h090, 32'h10, "R5 remaining swi");
    wr(12'h048, 32'h0); idle(2);
    pin(irq_o, 1, "R10 reopen fires");
    rd(12'h040, 32'd4, "R10 source after reopen");
    src_i[4] = 0; idle(2);
    rd(12'h098, 32'h10, "R4 fall keeps swi");
    wr(12'h094, 32'h10);
    wr(12'h048, 32'h1); idle(2);
    pin(irq_o, 0, "R9 nothing pending");
    // R7 arbitration
    wr(12'h048, 32'h4);
    wr(12'h104, 32'h14);
    wr(12'h1A4, 32'h08);
    wr(12'h21C, 32'h08);
    wr(12'h088, 32'h2); wr(12'h0A8, 32'h200); wr(12'h0C8, 32'h80);
    wr(12'h090, 32'h2); wr(12'h0B0, 32'h200); wr(12'h0D0, 32'h80);
    wr(12'h048, 32'h0); idle(2);
    pin(irq_o, 1, "R7 fire");
    rd(12'h040, 32'd71, "R7 tie to highest line");
    wr(12'h21C, 32'h0C); idle(2);
    rd(12'h040, 32'd71, "R8 source held while disarmed");
    wr(12'h048, 32'h1); idle(2);
    rd(12'h040, 32'd41, "R7 lower value wins");
    // R13 FIQ route
    wr(12'h104, 32'h15); idle(2);
    pin(fiq_o, 1, "R13 fiq asserts");
    rd(12'h044, 32'd1, "R13 fiq source");
    rd(12'h09C, 32'h2, "R13 pending fiq view");
    rd(12'h098, 32'h0, "R13 pending irq view");
    pin(irq_o, 1, "R13 irq unaffected");
    wr(12'h048, 32'h2);
    pin(fiq_o, 0, "R9 fiq dropped");
    pin(irq_o, 1, "R9 irq kept");
    idle(1);
    pin(fiq_o, 1, "R9 fiq refires");
    // R11 soft reset
    wr(12'h010, 32'h3); idle(1);
    pin(irq_o, 0, "R11 irq low");
    pin(fiq_o, 0, "R11 fiq low");
    rd(12'h0A4, 32'hFFFF_FFFF, "R11 mask restored");
    rd(12'h0B0, 32'h0, "R11 software cleared");
    rd(12'h010, 32'h0, "R11 sysconfig cleared");
    rd(12'h040, 32'h0, "R11 source cleared");
    rd(12'h104, 32'h0, "R11 line word cleared");
    idle(3);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL missing read data act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule